// File: doc/BRIEF.md
# Shift-Register Challenge-Response Unit

This unit answers a power-up authentication challenge. The host presents seven 4-bit challenge nibbles, here called C0 to C6, on one 28-bit input and pulses `start`. The unit loads an 8-bit right-shifting feedback register with a fixed seed. It advances that register by a count taken from C0 and C1. It then produces seven answer nibbles. Each answer nibble is built by folding selected inverted challenge nibbles into an accumulator, and successive register bits decide which nibbles take part.

The register advances one step per clock, so a request takes between 50 and 177 cycles. `busy` is high while a request runs. `done` then rises and stays high, and `answer` holds the eight result nibbles until the next accepted start.

Top module: `chal_resp_gen`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `answer` is all zeros.
- R2: One register step is defined as follows: if bit 0 is set, XOR the state with 0x90, then shift the state right by one. The seed is 0x22. Before the first answer nibble, the seed is stepped n times, where n = (C0*16 + C1) mod 128. Nibble Ck sits at `chal[4k+3:4k]`.
- R3: Answer nibbles 1 to 7 are computed in ascending order. Each one starts from an accumulator of 0 and a working copy of the current seed. Seven times over, the unit tests bit 0 of the working state and then steps the state. A set bit XORs the inverse of a challenge nibble into the accumulator. The nibbles are taken in the order C2, C1, C0, C6, C5, C4, C3. The answer nibble is the inverse of the accumulator. Answer nibble i sits at `answer[4i+3:4i]`.
- R4: The seed used for the next answer nibble is the working state after the first step of the current nibble, not after the last.
- R5: Answer nibble 0 is 0xF when C0 is 0xF, and 0 otherwise.
- R6: `done` rises exactly n+50 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until that same edge. `busy` and `done` are never high together.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the answer nor the completion time of the running request.
- R8: While idle, `done` and `answer` hold their values until a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (accepted only while idle) |
| chal | input | 28 | Challenge nibbles C0..C6, C0 in the low nibble |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid, held until the next accepted start |
| answer | output | 32 | Answer nibbles 0..7, nibble 0 in the low bits |

## Verification
A wrong register state never shows up as an error flag. It shows only as wrong answer nibbles, or as a wrong completion time, at the moment `done` rises. A miscount in the pre-advance shifts every later nibble and moves `done` by the same number of cycles. A wrong seed carried between nibbles corrupts only nibbles 2 to 7. Each case therefore comes into view n+50 cycles after start, through the answer compared against an arithmetic model and through an exact count of the cycles to `done`. Sweeping every C0/C1 pair exercises every pre-advance length from 0 to 127.

// File: rtl/chal_resp_gen.sv
module chal_resp_gen #(
  parameter int unsigned NIB = 4,
  parameter int unsigned LW = 8,
  parameter logic [7:0] SEED = 8'h22,
  parameter logic [7:0] FBMASK = 8'h90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7*NIB-1:0] chal,
  output logic             busy,
  output logic             done,
  output logic [8*NIB-1:0] answer
);
  localparam int unsigned CW = LW - 1;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_RND} st_t;

  st_t              st;
  logic [7*NIB-1:0] chal_q;
  logic [7*NIB-1:0] ans_q;
  logic [LW-1:0]    seed, work;
  logic [CW-1:0]    cnt;
  logic [2:0]       tap, idx;
  logic [NIB-1:0]   acc, nib, acc_nx;

  function automatic logic [LW-1:0] step(input logic [LW-1:0] s);
    return (s[0] ? (s ^ FBMASK[LW-1:0]) : s) >> 1;
  endfunction

  function automatic int tap_src(input logic [2:0] t);
    case (t)
      3'd0: return 2;
      3'd1: return 1;
      3'd2: return 0;
      3'd3: return 6;
      3'd4: return 5;
      3'd5: return 4;
      default: return 3;
    endcase
  endfunction

  wire [CW-1:0] pre_n = CW'({chal[NIB-1:0], chal[2*NIB-1:NIB]});

  assign nib    = chal_q[NIB*tap_src(tap) +: NIB];
  assign acc_nx = work[0] ? (acc ^ ~nib) : acc;
  assign answer = {ans_q, {NIB{chal_q[NIB-1:0] == {NIB{1'b1}}}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      chal_q <= '0;
      ans_q  <= '0;
      seed   <= '0;
      work   <= '0;
      cnt    <= '0;
      tap    <= '0;
      idx    <= '0;
      acc    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          chal_q <= chal;
          seed   <= SEED[LW-1:0];
          cnt    <= pre_n;
          busy   <= 1'b1;
          done   <= 1'b0;
          st     <= S_PRE;
        end
        S_PRE: if (cnt != '0) begin
          seed <= step(seed);
          cnt  <= cnt - 1'b1;
        end else begin
          work <= seed;
          acc  <= '0;
          tap  <= '0;
          idx  <= 3'd1;
          st   <= S_RND;
        end
        S_RND: begin
          work <= step(work);
          acc  <= acc_nx;
          tap  <= tap + 3'd1;
          if (tap == 3'd0) seed <= step(work);
          if (tap == 3'd6) begin
            ans_q[NIB*(int'(idx)-1) +: NIB] <= ~acc_nx;
            acc  <= '0;
            tap  <= '0;
            work <= seed;
            idx  <= idx + 3'd1;
            if (idx == 3'd7) begin
              st   <= S_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chal_resp_chk.sv
module chal_resp_chk #(
  parameter int unsigned NIB = 4,
  parameter int unsigned MAXBUSY = 178
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [8*NIB-1:0] answer
);
  int unsigned bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bcnt <= 0;
    else bcnt <= bcnt + 1;
  end

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));

  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) bcnt <= MAXBUSY);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(answer)));

  // R5
  nib0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (answer[NIB-1:0] == '0 || answer[NIB-1:0] == {NIB{1'b1}}));
endmodule

bind chal_resp_gen chal_resp_chk #(.NIB(NIB)) u_chk (.*);

// File: tb/sim_chal_resp_gen.sv
module sim_chal_resp_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] chal = '0;
  logic        busy, done;
  logic [31:0] answer;
  int checks = 0, errors = 0, cyc_total = 0;

  always #4 clk = ~clk;

  chal_resp_gen u0 (.clk, .rst_n, .start, .chal, .busy, .done, .answer);

  function automatic logic [7:0] mstep(input logic [7:0] s);
    logic [7:0] t;
    t = s[0] ? s ^ 8'h90 : s;
    return t >> 1;
  endfunction

  function automatic logic [31:0] model(input logic [27:0] c);
    logic [31:0] r;
    logic [7:0]  s, w;
    logic [3:0]  a;
    int ord[7];
    int n;
    ord = '{2, 1, 0, 6, 5, 4, 3};
    r = '0;
    s = 8'h22;
    n = (int'(c[3:0]) * 16 + int'(c[7:4])) % 128;
    for (int k = 0; k < n; k++) s = mstep(s);
    for (int i = 1; i < 8; i++) begin
      a = 4'h0;
      w = s;
      for (int t = 0; t < 7; t++) begin
        if (w[0]) a = a ^ ~c[4*ord[t] +: 4];
        w = mstep(w);
        if (t == 0) s = w;
      end
      r[4*i +: 4] = ~a;
    end
    r[3:0] = (c[3:0] == 4'hF) ? 4'hF : 4'h0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [27:0] c, input bit poke);
    int n, cyc;
    logic [31:0] exp;
    exp = model(c);
    n = (int'(c[3:0]) * 16 + int'(c[7:4])) % 128;
    @(negedge clk);
    chal = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", {31'd0, busy}, 32'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 400) begin
      if (poke && cyc == 10) begin
        chal = ~c;
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == n + 50, "R6 latency", cyc, n + 50);
    chk(answer[31:4] === exp[31:4], poke ? "R7 answer after ignored start" : "R2/R3/R4 answer",
        answer, exp);
    chk(answer[3:0] === exp[3:0], "R5 nibble 0", answer, exp);
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && answer === '0, "R1 reset state",
        {busy, done, answer[29:0]}, 32'd0);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        logic [27:0] c;
        c[3:0] = 4'(a);
        c[7:4] = 4'(b);
        c[27:8] = 20'(a * 40503 + b * 9973 + 12345);
        run(c, 1'b0);
      end

    run(28'h5A3C_F17, 1'b1);
    run(28'hFFF_FFFF, 1'b1);
    run(28'h000_0000, 1'b0);

    held = answer;
    repeat (20) @(negedge clk);
    chk(done === 1'b1 && answer === held, "R8 hold while idle", answer, held);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule